// File: doc/BRIEF.md
# Serial Crosspoint Chain Programmer

This block is the host-side engine that loads routing configurations into a chain of analog crosspoint devices wired in series through their serial data pins. Each device in the chain has sixteen outputs. Every output takes an enable flag and a 5-bit source number. Each device also has one clamp-control bit. The routing tables for all devices arrive as flat parallel vectors. A single start pulse then serializes the whole chain's configuration onto one data line, one bit per serial clock, and ends with one commit strobe that switches every device at the same moment.

Each device takes a 193-bit frame. Because bits ripple from the nearest device to the farthest, the frame for the last device in the chain goes out first. The block drives chip select low for the whole transfer. It holds the commit line (active low) high while bits shift. Once the last bit is in, it pulses the commit line low, raises chip select and reports completion. Every setup, hold, clock-phase, period and commit-gap minimum is a parameter counted in system clock cycles. After its own reset, the block holds the devices in reset with the commit line high, and only then releases them.

Top module: `xp_chain_prog`

## Requirements
- R1: One accepted start produces exactly NUM_DEV*193 rising edges on `xpSclk` before the commit pulse. The frame uses NUM_OUT=16 and SEL_W=5.
- R2: The frame for device index NUM_DEV-1 (farthest from the host) is sent first, and the frame for device 0 is sent last.
- R3: A frame is laid out as follows:
  - Bit 0 of the frame is `tblClamp[d]`.
  - For outputs o=15 down to 0, the frame carries `tblEn[d*16+o]` followed by the select bits `tblSel[(d*16+o)*5+4]` down to `tblSel[(d*16+o)*5+0]`.
  - The frame ends with 96 zero bits.
- R4: `xpCsN` is low at every rising edge of `xpSclk`, and `xpUpdN` is high at every rising edge of `xpSclk`.
- R5: `xpSdata` is unchanged for at least SETUP_CYC cycles before each rising edge of `xpSclk`. It is also unchanged for at least HOLD_CYC cycles after each rising edge.
- R6: Each high phase of `xpSclk` lasts at least HIGH_CYC cycles, and each low phase lasts at least LOW_CYC cycles. Successive rising edges are at least PERIOD_CYC cycles apart.
- R7: The low pulse on `xpUpdN` begins at least GAP_CYC cycles after the final rising edge of `xpSclk` and lasts exactly UPD_CYC cycles.
- R8: While `rstN` is low, and afterwards until the PWR_CYC-th rising clock edge after `rstN` is released, the outputs are held as follows: `xpRstN` low, `xpUpdN` high and `xpCsN` high. `xpUpdN` never goes low before a complete stream has been shifted.
- R9: In the cycle that `xpUpdN` returns high, `xpCsN` goes high and `done` is high for exactly one cycle. On the next cycle `busy` is low.
- R10: A start request that arrives while `busy` is high is ignored. It does not restart the stream, and it does not launch a second transfer after `done`.
- R11: The tables are captured when a start is accepted. Changes on `tblEn`, `tblSel` or `tblClamp` while `busy` is high do not alter the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin programming the chain (one cycle; ignored when busy) |
| tblEn | input | NUM_DEV*NUM_OUT | Output enable flags, bit d*NUM_OUT+o |
| tblSel | input | NUM_DEV*NUM_OUT*SEL_W | Source numbers, field d*NUM_OUT+o, LSB at lowest index |
| tblClamp | input | NUM_DEV | Clamp-control bit per device |
| busy | output | 1 | Power-up sequence or transfer in progress |
| done | output | 1 | One-cycle pulse when the commit strobe ends |
| xpCsN | output | 1 | Chip select to the chain, active low |
| xpSclk | output | 1 | Serial clock to the chain |
| xpSdata | output | 1 | Serial data into the nearest device |
| xpUpdN | output | 1 | Commit strobe to all devices, active low |
| xpRstN | output | 1 | Reset to all devices, active low |

## Verification
Every pin is decoded from registered state, so a change takes effect on the clock edge after its cause. For example, `xpCsN` falls one edge after an accepted start, and the first rising serial edge follows max(LOW_CYC, SETUP_CYC, PERIOD_CYC-high phase) cycles later. With the default timing, rising serial edges are 30 cycles apart. The commit pulse starts 20 cycles after the last rising edge and lasts 8 cycles, and `done` coincides with its end.

The bench samples all pins on the falling clock edge and records the cycle of every serial edge, data change and commit transition. It then compares those distances with the minimums, which gives each timing result a fixed place to be observed. It also compares the captured stream bit by bit with a frame model computed arithmetically from the tables. Reset release is counted in falling edges, where `xpRstN` is expected to rise after PWR_CYC-1 of them.

// File: rtl/xp_chain_pkg.sv
package xp_chain_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_PWRUP,   // holding the chain in reset, commit line high
    ST_IDLE,
    ST_LOW,     // serial clock low, data presented
    ST_HIGH,    // serial clock high, data held
    ST_GAP,     // quiet time between last edge and commit
    ST_COMMIT,  // commit line low
    ST_FINISH   // commit released, done pulse
  } seqState_t;

  // Strobes from control to the bit datapath
  typedef struct packed {
    logic load;  // capture tables, rewind to first bit
    logic step;  // advance to the next stream bit
  } dpCtl_t;

endpackage

// File: rtl/xp_chain_dp.sv
module xp_chain_dp
  import xp_chain_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int NUM_OUT = 16,
  parameter int SEL_W   = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpCtl_t                           ctl,
  input  logic [NUM_DEV*NUM_OUT-1:0]       tblEn,
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] tblSel,
  input  logic [NUM_DEV-1:0]               tblClamp,
  output logic                             bitOut,
  output logic                             lastBit
);

  localparam int FIELD_W    = SEL_W + 1;
  localparam int BODY_BITS  = NUM_OUT * FIELD_W;
  localparam int FRAME_BITS = 1 + 2 * BODY_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int OUT_W      = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int FLD_W      = $clog2(FIELD_W);
  localparam int SB_W       = (SEL_W > 1) ? $clog2(SEL_W) : 1;

  localparam logic [POS_W-1:0] BODY_LAST  = POS_W'(BODY_BITS);
  localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [OUT_W-1:0] OUT_TOP    = OUT_W'(NUM_OUT - 1);
  localparam logic [FLD_W-1:0] FLD_LAST   = FLD_W'(FIELD_W - 1);
  localparam logic [DEV_W-1:0] DEV_TOP    = DEV_W'(NUM_DEV - 1);

  // Snapshot taken when a transfer is accepted
  logic [NUM_DEV-1:0][NUM_OUT-1:0]            snapEn;
  logic [NUM_DEV-1:0][NUM_OUT-1:0][SEL_W-1:0] snapSel;
  logic [NUM_DEV-1:0]                         snapClamp;

  // Stream position: device, bit in frame, output and field within body
  logic [DEV_W-1:0] devIdx;
  logic [POS_W-1:0] posIdx;
  logic [OUT_W-1:0] outIdx;
  logic [FLD_W-1:0] fldIdx;

  logic             inBody;
  logic [SB_W-1:0]  selBit;
  logic [NUM_DEV-1:0] devBit;

  assign inBody = (posIdx != '0) && (posIdx <= BODY_LAST);
  // field 1 carries the select MSB, the last field its LSB
  assign selBit = SB_W'(SEL_W - int'(fldIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapEn    <= '0;
      snapSel   <= '0;
      snapClamp <= '0;
      devIdx    <= '0;
      posIdx    <= '0;
      outIdx    <= '0;
      fldIdx    <= '0;
    end else if (ctl.load) begin
      snapEn    <= tblEn;
      snapSel   <= tblSel;
      snapClamp <= tblClamp;
      devIdx    <= DEV_TOP;
      posIdx    <= '0;
      outIdx    <= OUT_TOP;
      fldIdx    <= '0;
    end else if (ctl.step) begin
      if (posIdx == FRAME_LAST) begin
        posIdx <= '0;
        devIdx <= devIdx - 1'b1;
        outIdx <= OUT_TOP;
        fldIdx <= '0;
      end else begin
        posIdx <= posIdx + 1'b1;
        if (inBody) begin
          if (fldIdx == FLD_LAST) begin
            fldIdx <= '0;
            outIdx <= outIdx - 1'b1;
          end else begin
            fldIdx <= fldIdx + 1'b1;
          end
        end
      end
    end
  end

  // One candidate bit per device, picked by the device counter
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic candBit;
    always_comb begin
      candBit = 1'b0;
      if (posIdx == '0) begin
        candBit = snapClamp[d];
      end else if (inBody) begin
        if (fldIdx == '0) candBit = snapEn[d][outIdx];
        else              candBit = snapSel[d][outIdx][selBit];
      end
    end
    assign devBit[d] = candBit;
  end

  assign bitOut  = devBit[devIdx];
  assign lastBit = (devIdx == '0) && (posIdx == FRAME_LAST);

endmodule

// File: rtl/xp_chain_ctl.sv
module xp_chain_ctl
  import xp_chain_pkg::*;
#(
  parameter int SETUP_CYC  = 8,
  parameter int HOLD_CYC   = 10,
  parameter int HIGH_CYC   = 10,
  parameter int LOW_CYC    = 10,
  parameter int PERIOD_CYC = 30,
  parameter int GAP_CYC    = 10,
  parameter int UPD_CYC    = 8,
  parameter int PWR_CYC    = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastBit,
  output dpCtl_t ctl,
  output logic   dataEn,
  output logic   busy,
  output logic   done,
  output logic   xpCsN,
  output logic   xpSclk,
  output logic   xpUpdN,
  output logic   xpRstN
);

  localparam int HIGH_A   = (HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC;
  localparam int HIGH_EFF = (HIGH_A > 1) ? HIGH_A : 1;
  localparam int LOW_A    = (LOW_CYC > SETUP_CYC) ? LOW_CYC : SETUP_CYC;
  localparam int LOW_B    = (LOW_A > PERIOD_CYC - HIGH_EFF) ? LOW_A : PERIOD_CYC - HIGH_EFF;
  localparam int LOW_EFF  = (LOW_B > 1) ? LOW_B : 1;
  localparam int GAP_EFF  = (GAP_CYC > 1) ? GAP_CYC : 1;
  localparam int UPD_EFF  = (UPD_CYC > 1) ? UPD_CYC : 1;
  localparam int PWR_EFF  = (PWR_CYC > 1) ? PWR_CYC : 1;
  localparam int MAX_AB   = (HIGH_EFF > LOW_EFF) ? HIGH_EFF : LOW_EFF;
  localparam int MAX_CD   = (GAP_EFF > UPD_EFF) ? GAP_EFF : UPD_EFF;
  localparam int MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_CYC  = (MAX_ABCD > PWR_EFF) ? MAX_ABCD : PWR_EFF;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(LOW_EFF - 1);
  localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(HIGH_EFF - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_EFF - 1);
  localparam logic [CNT_W-1:0] UPD_END  = CNT_W'(UPD_EFF - 1);
  localparam logic [CNT_W-1:0] PWR_END  = CNT_W'(PWR_EFF - 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] waitCnt;
  logic             cntClr;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    cntClr   = 1'b0;
    unique case (state)
      ST_PWRUP:  if (waitCnt == PWR_END) begin stateNxt = ST_IDLE; cntClr = 1'b1; end
      ST_IDLE: begin
        cntClr = 1'b1;
        if (start) begin
          ctl.load = 1'b1;
          stateNxt = ST_LOW;
        end
      end
      ST_LOW:    if (waitCnt == LOW_END) begin stateNxt = ST_HIGH; cntClr = 1'b1; end
      ST_HIGH: begin
        if (waitCnt == HIGH_END) begin
          cntClr = 1'b1;
          if (lastBit) begin
            stateNxt = ST_GAP;
          end else begin
            ctl.step = 1'b1;
            stateNxt = ST_LOW;
          end
        end
      end
      ST_GAP:    if (waitCnt == GAP_END) begin stateNxt = ST_COMMIT; cntClr = 1'b1; end
      ST_COMMIT: if (waitCnt == UPD_END) begin stateNxt = ST_FINISH; cntClr = 1'b1; end
      ST_FINISH: begin stateNxt = ST_IDLE; cntClr = 1'b1; end
      default:   begin stateNxt = ST_IDLE; cntClr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PWRUP;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      waitCnt <= cntClr ? '0 : waitCnt + 1'b1;
    end
  end

  // Pin decode from the registered phase
  assign dataEn = (state == ST_LOW) || (state == ST_HIGH);
  assign xpSclk = (state == ST_HIGH);
  assign xpCsN  = !((state == ST_LOW) || (state == ST_HIGH) ||
                    (state == ST_GAP) || (state == ST_COMMIT));
  assign xpUpdN = (state != ST_COMMIT);
  assign xpRstN = (state != ST_PWRUP);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FINISH);

endmodule

// File: rtl/xp_chain_prog.sv
module xp_chain_prog
  import xp_chain_pkg::*;
#(
  parameter int NUM_DEV    = 2,
  parameter int NUM_OUT    = 16,
  parameter int SEL_W      = 5,
  parameter int SETUP_CYC  = 8,
  parameter int HOLD_CYC   = 10,
  parameter int HIGH_CYC   = 10,
  parameter int LOW_CYC    = 10,
  parameter int PERIOD_CYC = 30,
  parameter int GAP_CYC    = 10,
  parameter int UPD_CYC    = 8,
  parameter int PWR_CYC    = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [NUM_DEV*NUM_OUT-1:0]       tblEn,
  input  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] tblSel,
  input  logic [NUM_DEV-1:0]               tblClamp,
  output logic                             busy,
  output logic                             done,
  output logic                             xpCsN,
  output logic                             xpSclk,
  output logic                             xpSdata,
  output logic                             xpUpdN,
  output logic                             xpRstN
);

  dpCtl_t dpCtl;
  logic   bitOut;
  logic   lastBit;
  logic   dataEn;

  xp_chain_ctl #(
    .SETUP_CYC (SETUP_CYC),  .HOLD_CYC (HOLD_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC   (LOW_CYC),    .PERIOD_CYC(PERIOD_CYC), .GAP_CYC(GAP_CYC),
    .UPD_CYC   (UPD_CYC),    .PWR_CYC  (PWR_CYC)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .lastBit(lastBit),
    .ctl    (dpCtl),
    .dataEn (dataEn),
    .busy   (busy),
    .done   (done),
    .xpCsN  (xpCsN),
    .xpSclk (xpSclk),
    .xpUpdN (xpUpdN),
    .xpRstN (xpRstN)
  );

  xp_chain_dp #(
    .NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .tblEn   (tblEn),
    .tblSel  (tblSel),
    .tblClamp(tblClamp),
    .bitOut  (bitOut),
    .lastBit (lastBit)
  );

  assign xpSdata = dataEn & bitOut;

endmodule

// File: rtl/xp_chain_prog_chk.sv
module xp_chain_prog_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic xpCsN,
  input logic xpSclk,
  input logic xpSdata,
  input logic xpUpdN,
  input logic xpRstN
);

  p_sclk_framed_r4: assert property (@(posedge clk) disable iff (!rstN)
    xpSclk |-> (!xpCsN && xpUpdN));

  p_data_stable_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xpSclk && $past(xpSclk)) |-> $stable(xpSdata));

  p_commit_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !xpUpdN |-> (!xpCsN && !xpSclk));

  p_reset_commit_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    !xpRstN |-> (xpUpdN && xpCsN));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_commit_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xpUpdN) |-> (done && xpCsN));

  p_select_from_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xpCsN) |-> ($past(start) && !$past(busy)));

endmodule

bind xp_chain_prog xp_chain_prog_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .xpCsN  (xpCsN),
  .xpSclk (xpSclk),
  .xpSdata(xpSdata),
  .xpUpdN (xpUpdN),
  .xpRstN (xpRstN)
);

// File: tb/xp_chain_prog_tb.sv
`timescale 1ns/1ps
module xp_chain_prog_tb;

  localparam int NUM_DEV    = 2;
  localparam int NUM_OUT    = 16;
  localparam int SEL_W      = 5;
  localparam int SETUP_CYC  = 8;
  localparam int HOLD_CYC   = 10;
  localparam int HIGH_CYC   = 10;
  localparam int LOW_CYC    = 10;
  localparam int PERIOD_CYC = 30;
  localparam int GAP_CYC    = 10;
  localparam int UPD_CYC    = 8;
  localparam int PWR_CYC    = 32;
  localparam int FW    = SEL_W + 1;
  localparam int BODY  = NUM_OUT * FW;
  localparam int FRAME = 1 + 2 * BODY;
  localparam int TOTAL = NUM_DEV * FRAME;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NUM_DEV*NUM_OUT-1:0]       tblEn = '0;
  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] tblSel = '0;
  logic [NUM_DEV-1:0]               tblClamp = '0;
  logic busy, done, xpCsN, xpSclk, xpSdata, xpUpdN, xpRstN;

  always #2.5 clk = ~clk;

  xp_chain_prog #(
    .NUM_DEV(NUM_DEV), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC(LOW_CYC), .PERIOD_CYC(PERIOD_CYC), .GAP_CYC(GAP_CYC),
    .UPD_CYC(UPD_CYC), .PWR_CYC(PWR_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .tblEn(tblEn), .tblSel(tblSel), .tblClamp(tblClamp),
    .busy(busy), .done(done), .xpCsN(xpCsN), .xpSclk(xpSclk),
    .xpSdata(xpSdata), .xpUpdN(xpUpdN), .xpRstN(xpRstN)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- pin monitor (falling edge sampling) ----------------
  int   cyc = 0;
  logic pSclk = 1'b0, pData = 1'b0, pUpdN = 1'b1, pCsN = 1'b1;
  int   lastRise = 0, lastFall = 0, lastChg = 0, updFall = 0;
  bit   haveRise = 0;
  int   bitCnt = 0;
  logic streamBits [TOTAL];
  int   vSetup = 0, vHold = 0, vHigh = 0, vLow = 0, vPer = 0, vFrame = 0;
  int   vGap = 0, vUpdW = 0, vEarly = 0, vEnd = 0, vPwr = 0;
  int   doneCnt = 0, csFallCnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (!xpRstN && !xpUpdN) vPwr++;
    if (rstN && xpRstN) begin
      if (pCsN && !xpCsN) begin
        csFallCnt++;
        bitCnt = 0;
        haveRise = 0;
        lastChg = cyc;
      end
      if (xpSdata !== pData) begin
        if (haveRise && (cyc - lastRise) < HOLD_CYC) vHold++;
        lastChg = cyc;
      end
      if (!pSclk && xpSclk) begin
        if (xpCsN || !xpUpdN) vFrame++;
        if ((cyc - lastChg) < SETUP_CYC) vSetup++;
        if (haveRise && (cyc - lastRise) < PERIOD_CYC) vPer++;
        if (haveRise && (cyc - lastFall) < LOW_CYC) vLow++;
        if (bitCnt < TOTAL) streamBits[bitCnt] = xpSdata;
        bitCnt++;
        lastRise = cyc;
        haveRise = 1;
      end
      if (pSclk && !xpSclk) begin
        if ((cyc - lastRise) < HIGH_CYC) vHigh++;
        lastFall = cyc;
      end
      if (pUpdN && !xpUpdN) begin
        updFall = cyc;
        if (!haveRise || (cyc - lastRise) < GAP_CYC) vGap++;
        if (bitCnt != TOTAL) vEarly++;
      end
      if (!pUpdN && xpUpdN) begin
        if ((cyc - updFall) != UPD_CYC) vUpdW++;
        if (!xpCsN || !done) vEnd++;
      end
      if (done) doneCnt++;
    end
    pSclk = xpSclk; pData = xpSdata; pUpdN = xpUpdN; pCsN = xpCsN;
  end

  // ---------------- expected stream ----------------
  logic [NUM_DEV*NUM_OUT-1:0]       expEn;
  logic [NUM_DEV*NUM_OUT*SEL_W-1:0] expSel;
  logic [NUM_DEV-1:0]               expClamp;

  function automatic logic expBit(input int k);
    int dev = NUM_DEV - 1 - k / FRAME;   // R2: farthest device first
    int p   = k % FRAME;
    if (p == 0) return expClamp[dev];
    if (p <= BODY) begin
      int q = p - 1;
      int o = NUM_OUT - 1 - q / FW;
      int f = q % FW;
      if (f == 0) return expEn[dev*NUM_OUT + o];
      return expSel[(dev*NUM_OUT + o)*SEL_W + SEL_W - f];
    end
    return 1'b0;
  endfunction

  task automatic fill(input int mode);
    for (int d = 0; d < NUM_DEV; d++) begin
      tblClamp[d] = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 :
                    (mode == 2) ? 1'(d % 2) : 1'(d == NUM_DEV - 1);
      for (int o = 0; o < NUM_OUT; o++) begin
        int s;
        bit e;
        case (mode)
          0: begin s = 0; e = 0; end
          1: begin s = (1 << SEL_W) - 1; e = 1; end
          2: begin s = (o*7 + d*11 + 3) % (1 << SEL_W); e = ((o + d) % 3) != 0; end
          default: begin s = (1 << SEL_W) - 1 - o; e = (o % 2) == 1; end
        endcase
        tblEn[d*NUM_OUT + o] = e;
        for (int b = 0; b < SEL_W; b++) tblSel[(d*NUM_OUT + o)*SEL_W + b] = 1'((s >> b) & 1);
      end
    end
  endtask

  task automatic run_program(input int mode, input bit poke, input bit disturb);
    int d0, c0, mism, firstBad, loops;
    fill(mode);
    expEn = tblEn; expSel = tblSel; expClamp = tblClamp;
    d0 = doneCnt; c0 = csFallCnt;
    vSetup = 0; vHold = 0; vHigh = 0; vLow = 0; vPer = 0; vFrame = 0;
    vGap = 0; vUpdW = 0; vEarly = 0; vEnd = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    loops = 0;
    while (doneCnt == d0 && loops < 20000) begin
      @(negedge clk);
      loops++;
      if (poke && (loops == 300 || loops == 5000)) start = 1'b1;
      else start = 1'b0;
      if (disturb && loops == 700) fill((mode + 1) % 4);
    end
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", int'(busy), 0, "busy after done");
    chk(xpCsN == 1'b1, "R9", int'(xpCsN), 1, "select high after done");
    chk(doneCnt - d0 == 1, "R9", doneCnt - d0, 1, "done pulses");
    chk(bitCnt == TOTAL, "R1", bitCnt, TOTAL, "serial edges");
    mism = 0; firstBad = -1;
    for (int k = 0; k < TOTAL; k++)
      if (streamBits[k] !== expBit(k)) begin
        mism++;
        if (firstBad < 0) firstBad = k;
      end
    chk(mism == 0, disturb ? "R11" : "R3", firstBad, -1, "first wrong stream bit (R2 order)");
    chk(vFrame == 0, "R4", vFrame, 0, "edges outside select or during commit");
    chk(vSetup == 0, "R5", vSetup, 0, "setup shortfalls");
    chk(vHold == 0, "R5", vHold, 0, "hold shortfalls");
    chk(vHigh + vLow == 0, "R6", vHigh + vLow, 0, "phase width shortfalls");
    chk(vPer == 0, "R6", vPer, 0, "period shortfalls");
    chk(vGap == 0, "R7", vGap, 0, "commit gap shortfalls");
    chk(vUpdW == 0, "R7", vUpdW, 0, "commit width errors");
    chk(vEarly == 0, "R8", vEarly, 0, "commit before full stream");
    chk(vEnd == 0, "R9", vEnd, 0, "commit end without select release/done");
    // R10: no restart mid-stream, nothing queued after done
    repeat (50) @(negedge clk);
    chk(csFallCnt - c0 == 1, "R10", csFallCnt - c0, 1, "transfers launched");
    chk(xpCsN == 1'b1 && bitCnt == TOTAL, "R10", bitCnt, TOTAL, "quiet after done");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pwrLow;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(xpRstN == 1'b0 && xpUpdN == 1'b1 && xpCsN == 1'b1, "R8",
        {xpRstN, xpUpdN, xpCsN}, 3'b011, "pins in reset");
    chk(xpSclk == 1'b0 && busy == 1'b1 && done == 1'b0, "R8",
        {xpSclk, busy, done}, 3'b010, "status in reset");
    rstN = 1'b1;
    pwrLow = 0;
    @(negedge clk);
    while (!xpRstN && pwrLow < 1000) begin
      pwrLow++;
      @(negedge clk);
    end
    // released at the PWR_CYC-th edge: PWR_CYC-1 falling edges still low
    chk(pwrLow == PWR_CYC - 1, "R8", pwrLow, PWR_CYC - 1, "device reset hold");
    chk(vPwr == 0, "R8", vPwr, 0, "commit low while devices in reset");
    chk(xpCsN == 1'b1 && busy == 1'b0, "R8", int'(busy), 0, "idle after power-up");

    run_program(0, 0, 0);
    run_program(1, 0, 0);
    run_program(2, 1, 0);   // R10 start pokes while busy
    run_program(3, 0, 1);   // R11 tables change while busy
    run_program(2, 1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule